// File: doc/BRIEF.md
# Posted Byte-Write Coalescing Scheduler

This block sits between a processor-side byte write port and the controller of an external burst memory that works in 16-bit words. Each byte write is acknowledged in the same cycle it is requested, so the processor never waits for the memory. Accepted bytes are gathered into a single buffer that covers one aligned eight-byte row. A bitmap records which of the eight byte lanes hold data that has not yet reached memory.

When the memory bus reports idle and the bitmap is not empty, the scheduler raises a transfer request toward the memory controller. The burst starts at the lowest 16-bit word of the row that holds a pending byte. The controller then pulls one byte per beat. With each byte the scheduler presents a byte-enable, which is low for lanes nobody wrote. The burst stops after the odd byte of the highest word that still has a pending byte, so every transfer covers whole words and never exceeds eight bytes.

A write to the same row may still join a burst that is already under way, as long as its lane has not gone past. A write to a lane that has gone past, or to another row, is held off until the memory controller reports the burst complete. The buffered row and bitmap are visible at the ports, so a read path can detect pending data for a row it is about to fetch.

Top module: `wr_coalescer`

## Requirements
- R1: After reset the bitmap `buf_pend` is zero, `mem_req` and `mem_last` are low, and no transfer starts until a byte has been accepted.
- R2: With the scheduler idle and the bitmap either empty or holding the same row (row = `wr_addr[AW-1:3]`), `wr_ack` is high in the same cycle as `wr_req`. From the next cycle, bit `wr_addr[2:0]` of `buf_pend` is set. Pending bits never clear except on completion.
- R3: While the bitmap is non-empty, a write to a row other than `buf_row` gets no acknowledge until the burst has completed.
- R4: `mem_req` rises in the cycle after a cycle in which the scheduler was idle, the bitmap was non-empty and `mem_idle` was high. It does not rise while `mem_idle` stays low.
- R5: During a burst, `mem_col` gives the lowest word index (byte lane / 2) that holds a pending byte. The first beat presents byte lane 2*`mem_col` on `mem_idx`, and each beat that is not the last advances `mem_idx` by one.
- R6: On each beat, `mem_be` equals the pending bit of lane `mem_idx` and `mem_data` is the newest byte written to that lane. `mem_last` is high only on an odd lane with no pending lane above it, so a burst covers whole words and at most eight bytes.
- R7: During a burst, a same-row write is acknowledged and merged when its lane is above `mem_idx`, or equal to it with no beat in that cycle. It extends the burst if it lies beyond the current end.
- R8: During a burst, a write is not acknowledged if its lane is below `mem_idx`, or equal to it while a beat occurs, or if it arrives in the cycle of the final beat. Between the final beat and `mem_done`, no write is acknowledged.
- R9: `mem_done` after the final beat clears `buf_pend` and returns the scheduler to idle with `mem_req` low. A held write is then accepted into the fresh buffer.
- R10: A second write to a pending lane that has not yet gone out replaces its data, and the burst carries the newer value.
- R11: `buf_row` and `buf_pend` show the buffered row and the pending lane bitmap at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Byte write request |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| wr_ack | output | 1 | Write accepted this cycle |
| mem_idle | input | 1 | Memory bus free to start a burst |
| mem_req | output | 1 | Burst in progress, beats may be taken |
| mem_row | output | AW-3 | Row address of the burst |
| mem_col | output | 2 | Starting word within the row |
| mem_idx | output | 3 | Byte lane presented on this beat |
| mem_data | output | 8 | Byte for the current lane |
| mem_be | output | 1 | Byte enable for the current lane |
| mem_last | output | 1 | Current beat ends the burst |
| mem_beat | input | 1 | Controller takes the current byte |
| mem_done | input | 1 | Controller finished the burst |
| buf_row | output | AW-3 | Buffered row address |
| buf_pend | output | 8 | Pending byte lane bitmap |

## Verification
On every cycle the assertions check the following. Writes to a foreign row are refused while data is pending. A burst only begins after an idle bus. The lane index steps by one per beat. The end beat falls on an odd lane. Nothing is acknowledged during the final beat or while waiting for completion. Pending bits only drop on completion. What only the bench scenarios show is the content of each burst. That covers the starting word, the per-lane enables and data for every one of the 255 non-empty lane patterns, and the newest-data rule on rewrites. It also covers the late-merge decisions against the moving lane index, including extension of a burst and the fresh buffer after a held write.

// File: rtl/wr_coalescer.sv
module wr_coalescer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          wr_ack,
  input  logic          mem_idle,
  output logic          mem_req,
  output logic [AW-4:0] mem_row,
  output logic [1:0]    mem_col,
  output logic [2:0]    mem_idx,
  output logic [7:0]    mem_data,
  output logic          mem_be,
  output logic          mem_last,
  input  logic          mem_beat,
  input  logic          mem_done,
  output logic [AW-4:0] buf_row,
  output logic [7:0]    buf_pend
);
  localparam int RW = AW - 3;
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_XFER = 2'd1;
  localparam logic [1:0] S_WAIT = 2'd2;

  logic [1:0]    st;
  logic [RW-1:0] row;
  logic [7:0]    pend;
  logic [63:0]   dat;
  logic [2:0]    pos;
  logic [1:0]    col;
  logic          ok;
  logic [1:0]    lo_w;

  wire [RW-1:0] in_row   = wr_addr[AW-1:3];
  wire [2:0]    in_b     = wr_addr[2:0];
  wire          same     = (in_row == row);
  wire [7:0]    above    = pend & (8'hFE << pos);
  wire          end_beat = mem_beat && mem_last;

  assign mem_last = (st == S_XFER) && pos[0] && (above == 8'h00);

  always_comb begin
    case (st)
      S_IDLE:  ok = (pend == 8'h00) || same;
      S_XFER:  ok = same && !end_beat && ((in_b > pos) || ((in_b == pos) && !mem_beat));
      default: ok = 1'b0;
    endcase
  end

  assign wr_ack = wr_req && ok;

  wire [7:0] bit_in   = 8'b1 << in_b;
  wire [7:0] pend_nxt = pend | (wr_ack ? bit_in : 8'h00);
  wire       go       = (st == S_IDLE) && (pend != 8'h00) && mem_idle;

  always_comb begin
    lo_w = 2'd3;
    for (int w = 3; w >= 0; w--)
      if (|pend_nxt[2*w +: 2]) lo_w = 2'(w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      row  <= '0;
      pend <= '0;
      dat  <= '0;
      pos  <= '0;
      col  <= '0;
    end else begin
      if (wr_ack) begin
        row               <= in_row;
        dat[8*in_b +: 8]  <= wr_data;
      end
      pend <= pend_nxt;
      case (st)
        S_IDLE: if (go) begin
          st  <= S_XFER;
          col <= lo_w;
          pos <= {lo_w, 1'b0};
        end
        S_XFER: if (mem_beat) begin
          if (mem_last) st <= S_WAIT;
          else          pos <= pos + 3'd1;
        end
        S_WAIT: if (mem_done) begin
          st   <= S_IDLE;
          pend <= '0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == S_XFER);
  assign mem_row  = row;
  assign mem_col  = col;
  assign mem_idx  = pos;
  assign mem_data = dat[8*pos +: 8];
  assign mem_be   = pend[pos];
  assign buf_row  = row;
  assign buf_pend = pend;
endmodule

// File: rtl/wr_coalescer_chk.sv
module wr_coalescer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic [AW-1:0] wr_addr,
  input logic          wr_ack,
  input logic          mem_idle,
  input logic          mem_req,
  input logic [2:0]    mem_idx,
  input logic          mem_last,
  input logic          mem_beat,
  input logic          mem_done,
  input logic [AW-4:0] buf_row,
  input logic [7:0]    buf_pend,
  input logic [1:0]    st
);
  assert_ack_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> wr_req);

  assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == 2'd2 && mem_done) |=> ((buf_pend & $past(buf_pend)) == $past(buf_pend)));

  assert_other_row_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && buf_pend != 8'h00 && wr_addr[AW-1:3] != buf_row) |-> !wr_ack);

  assert_start_on_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(mem_idle));

  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_beat && !mem_last) |=> (mem_idx == $past(mem_idx) + 3'd1));

  assert_last_odd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_last |-> (mem_req && mem_idx[0]));

  assert_end_beat_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_beat && mem_last) |-> !wr_ack);

  assert_wait_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |-> !wr_ack);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && mem_done) |=> (buf_pend == 8'h00 && !mem_req));
endmodule

bind wr_coalescer wr_coalescer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr), .wr_ack(wr_ack),
  .mem_idle(mem_idle), .mem_req(mem_req), .mem_idx(mem_idx), .mem_last(mem_last),
  .mem_beat(mem_beat), .mem_done(mem_done), .buf_row(buf_row), .buf_pend(buf_pend),
  .st(st)
);

// File: tb/test_wr_coalescer.sv
module test_wr_coalescer;
  localparam int AW = 16;
  localparam time TCLK = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_ack;
  logic          mem_idle = 1'b0;
  logic          mem_req;
  logic [AW-4:0] mem_row;
  logic [1:0]    mem_col;
  logic [2:0]    mem_idx;
  logic [7:0]    mem_data;
  logic          mem_be;
  logic          mem_last;
  logic          mem_beat = 1'b0;
  logic          mem_done = 1'b0;
  logic [AW-4:0] buf_row;
  logic [7:0]    buf_pend;

  int  nchk = 0;
  int  nfail = 0;
  bit  ended = 1'b0;
  logic [7:0] exp_d [8];

  always #(TCLK/2) clk = ~clk;

  wr_coalescer #(.AW(AW)) i_wr_coalescer (.*);

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-4:0] r, input int b, input logic [7:0] d,
                    input bit exp_ack, input string tag);
    wr_req  = 1'b1;
    wr_addr = {r, 3'(b)};
    wr_data = d;
    #1 chk(wr_ack == exp_ack, tag, int'(wr_ack), int'(exp_ack));
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic start_flush(input int lo, input logic [AW-4:0] r);
    mem_idle = 1'b1;
    @(negedge clk);
    mem_idle = 1'b0;
    #1;
    chk(mem_req == 1'b1, "R4 request raised", int'(mem_req), 1);
    chk(mem_col == 2'(lo), "R5 start word", int'(mem_col), lo);
    chk(mem_row == r, "R11 burst row", int'(mem_row), int'(r));
  endtask

  task automatic finish_flush(input int lo, input int hi, input logic [7:0] m);
    for (int i = 2*lo; i <= 2*hi+1; i++) begin
      mem_beat = 1'b1;
      #1;
      chk(mem_idx == 3'(i), "R5 lane index", int'(mem_idx), i);
      chk(mem_be == m[i], "R6 byte enable", int'(mem_be), int'(m[i]));
      if (m[i]) chk(mem_data == exp_d[i], "R6 lane data", int'(mem_data), int'(exp_d[i]));
      chk(mem_last == (i == 2*hi+1), "R6 last beat", int'(mem_last), int'(i == 2*hi+1));
      @(negedge clk);
    end
    mem_beat = 1'b0;
    #1 chk(mem_req == 1'b0, "R9 request drops after last", int'(mem_req), 0);
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    #1;
    chk(buf_pend == 8'h00, "R9 bitmap cleared", int'(buf_pend), 0);
    chk(mem_req == 1'b0, "R9 idle after done", int'(mem_req), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!ended) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(buf_pend == 8'h00, "R1 bitmap after reset", int'(buf_pend), 0);
    chk(mem_req == 1'b0, "R1 request after reset", int'(mem_req), 0);
    chk(mem_last == 1'b0, "R1 last after reset", int'(mem_last), 0);
    mem_idle = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(mem_req == 1'b0, "R1 no burst when empty", int'(mem_req), 0);
    mem_idle = 1'b0;
    @(negedge clk);

    // Sweep every non-empty lane pattern: R2 R4 R5 R6 R9 R11
    for (int m = 1; m < 256; m++) begin
      logic [AW-4:0] r;
      int lo, hi;
      r  = (AW-3)'(m * 37 + 5);
      lo = 4; hi = -1;
      for (int k = 0; k < 8; k++) begin
        int b;
        b = (m % 2 == 1) ? 7 - k : k;
        if (m[b]) begin
          exp_d[b] = 8'(m * 7 + b * 29 + 90);
          wr(r, b, exp_d[b], 1'b1, "R2 posted ack");
          if (b/2 < lo) lo = b/2;
          if (b/2 > hi) hi = b/2;
        end
      end
      #1;
      chk(buf_pend == 8'(m), "R11 bitmap", int'(buf_pend), m);
      chk(buf_row == r, "R11 row", int'(buf_row), int'(r));
      @(negedge clk);
      #1 chk(mem_req == 1'b0, "R4 no burst while bus busy", int'(mem_req), 0);
      start_flush(lo, r);
      finish_flush(lo, hi, 8'(m));
    end

    // R3: foreign row refused while pending
    exp_d[1] = 8'hA1;
    wr(13'h0100, 1, 8'hA1, 1'b1, "R2 ack");
    wr(13'h0200, 1, 8'hB2, 1'b0, "R3 other row stalled");
    #1 chk(buf_pend == 8'h02, "R3 foreign write left bitmap", int'(buf_pend), 2);
    start_flush(0, 13'h0100);
    finish_flush(0, 0, 8'h02);
    wr(13'h0200, 1, 8'hB2, 1'b1, "R3 accepted after done");
    exp_d[1] = 8'hB2;
    start_flush(0, 13'h0200);
    finish_flush(0, 0, 8'h02);

    // R10: rewrite of a pending lane
    exp_d[4] = 8'h22;
    wr(13'h0300, 4, 8'h11, 1'b1, "R10 first write");
    wr(13'h0300, 4, 8'h22, 1'b1, "R10 rewrite");
    start_flush(2, 13'h0300);
    finish_flush(2, 2, 8'h10);

    // R7 and R8: late writes against lane index 2
    exp_d[3] = 8'h33;
    wr(13'h0400, 3, 8'h33, 1'b1, "R2 ack");
    start_flush(1, 13'h0400);
    exp_d[6] = 8'h66;
    wr(13'h0400, 6, 8'h66, 1'b1, "R7 late merge above index");
    exp_d[2] = 8'h44;
    wr(13'h0400, 2, 8'h44, 1'b1, "R7 late merge at index without beat");
    wr(13'h0400, 1, 8'h55, 1'b0, "R8 lane already passed");
    wr(13'h0500, 7, 8'h55, 1'b0, "R3 other row during burst");
    finish_flush(1, 3, 8'h4C);

    // R8: same lane during beat, final beat, wait phase; R9 fresh buffer
    exp_d[0] = 8'h0F;
    wr(13'h0600, 0, 8'h0F, 1'b1, "R2 ack");
    start_flush(0, 13'h0600);
    mem_beat = 1'b1;
    wr_req = 1'b1; wr_addr = {13'h0600, 3'd0}; wr_data = 8'hEE;
    #1;
    chk(wr_ack == 1'b0, "R8 lane sent on this beat", int'(wr_ack), 0);
    chk(mem_data == 8'h0F, "R6 lane data", int'(mem_data), 8'h0F);
    @(negedge clk);
    wr_addr = {13'h0600, 3'd5}; wr_data = 8'h5E;
    #1;
    chk(mem_last == 1'b1, "R6 last on odd lane", int'(mem_last), 1);
    chk(wr_ack == 1'b0, "R8 write on final beat", int'(wr_ack), 0);
    @(negedge clk);
    mem_beat = 1'b0;
    mem_done = 1'b1;
    #1 chk(wr_ack == 1'b0, "R8 write while awaiting done", int'(wr_ack), 0);
    @(negedge clk);
    mem_done = 1'b0;
    #1 chk(wr_ack == 1'b1, "R9 held write into fresh buffer", int'(wr_ack), 1);
    @(negedge clk);
    wr_req = 1'b0;
    #1 chk(buf_pend == 8'h20, "R9 fresh bitmap", int'(buf_pend), 8'h20);
    exp_d[5] = 8'h5E;
    start_flush(2, 13'h0600);
    finish_flush(2, 2, 8'h20);

    // R7: extension past an odd lane that would have ended the burst
    exp_d[1] = 8'h71;
    wr(13'h0700, 1, 8'h71, 1'b1, "R2 ack");
    start_flush(0, 13'h0700);
    mem_beat = 1'b1;
    #1 chk(mem_idx == 3'd0, "R5 lane index", int'(mem_idx), 0);
    @(negedge clk);
    mem_beat = 1'b0;
    #1 chk(mem_last == 1'b1, "R6 last before extension", int'(mem_last), 1);
    exp_d[7] = 8'h77;
    wr(13'h0700, 7, 8'h77, 1'b1, "R7 extension write");
    #1 chk(mem_last == 1'b0, "R7 burst extended", int'(mem_last), 0);
    for (int i = 1; i <= 7; i++) begin
      mem_beat = 1'b1;
      #1;
      chk(mem_idx == 3'(i), "R7 extended lane index", int'(mem_idx), i);
      chk(mem_be == (i == 1 || i == 7), "R7 extended enable", int'(mem_be), int'(i == 1 || i == 7));
      if (i == 7) chk(mem_data == 8'h77, "R7 extended data", int'(mem_data), 8'h77);
      @(negedge clk);
    end
    mem_beat = 1'b0;
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    #1 chk(buf_pend == 8'h00, "R9 bitmap cleared", int'(buf_pend), 0);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule